// File: doc/BRIEF.md
# DSP Multiply-Accumulate and Accumulator Unit

This block is the arithmetic slice of a 16-bit signal-processing core. It keeps a 32-bit accumulator, a 32-bit product register and a 16-bit status word. Each accepted operation updates them on a single clock edge. The product is always twice the signed product of two 16-bit operand words. The multiply forms fold the product already held into the accumulator, and in the same cycle capture a new product from the operand words presented with the operation.

Word-sized ALU operations act on the upper half of the accumulator: the 16-bit source sits in bits 31..16 with zeros below. The same operations can take the product register as a full 32-bit source. An 8-bit short immediate form is also provided, along with four single-operand modify operations. The zero and negative flags always describe a full 32-bit result. An instruction decoder drives the operation select, the source select and the data words, and holds `op_valid` high for one cycle per instruction.

Top module: `mac_acc_unit`

## Requirements
- R1: After reset the accumulator, the product register and the status word are all zero.
- R2: While `op_valid` is low, or when `op_sel` is 0 (no-op) or 15, the accumulator, product and status hold their values.
- R3: Multiply-load (`op_sel`=12), multiply-add (13) and multiply-subtract (14) set the product to the signed product of `x_in` and `y_in` times two, modulo 2^32, one edge after the operation.
- R4: Multiply-load clears the accumulator to zero and sets Z.
- R5: Multiply-add adds, and multiply-subtract subtracts, the product held before the operation to or from the 32-bit accumulator.
- R6: With `src_sel`=0 the source is `operand` shifted left by 16, for add (2), subtract (3), AND (5), OR (6) and XOR (7).
- R7: Compare (4) leaves the accumulator unchanged and sets the flags from the accumulator minus the source.
- R8: With `src_sel`=1 the source is the full 32-bit product register.
- R9: With `src_sel`=2 the source is `operand[7:0]` zero-extended and shifted left by 16, and `operand[15:8]` has no effect. A `src_sel` of 3 acts as 0.
- R10: Every operation other than load and no-op writes the status word as follows: bit 13 (Z) is set when the 32-bit result is zero, bit 15 (N) is result bit 31, and bits 12 and 14 are cleared. No other status bit ever becomes set.
- R11: Load (1) leaves the status unchanged. From the product source it copies the product into the accumulator. Otherwise it writes the source's upper 16 bits into accumulator bits 31..16 and keeps bits 15..0.
- R12: Arithmetic shift right (8) replicates bit 31, shift left (9) fills with zero, negate (10) forms the two's complement, and absolute value (11) negates only when bit 31 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_sel | input | 4 | Operation code |
| src_sel | input | 2 | Source select for ALU and load operations |
| operand | input | 16 | Word or short-immediate source |
| x_in | input | 16 | First multiplier operand |
| y_in | input | 16 | Second multiplier operand |
| acc_o | output | 32 | Accumulator |
| prod_o | output | 32 | Product register |
| status_o | output | 16 | Status word (Z at bit 13, N at bit 15) |

## Verification
The hardest state to reach is the corner of the product and the accumulator. Both operands at -32768 give a product of exactly 0x80000000. Absolute value or negate then applied to that pattern must leave it unchanged and report N set. Directed sequences load this product, move it into the accumulator through the product source, and then apply the modify operations. A constrained-random stream adds further cases. It is weighted toward multiply chains, so that folding the earlier product into the accumulator is exercised back to back.

// File: rtl/mac_pkg.sv
package mac_pkg;
    localparam int unsigned MAC_DW   = 16;
    localparam int unsigned MAC_AW   = 2 * MAC_DW;
    localparam int unsigned MAC_IMMW = 8;
    localparam int unsigned MAC_SW   = 16;
    localparam int unsigned ST_L     = 12;
    localparam int unsigned ST_Z     = 13;
    localparam int unsigned ST_V     = 14;
    localparam int unsigned ST_N     = 15;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,  OP_LOAD = 4'd1,  OP_ADD  = 4'd2,  OP_SUB  = 4'd3,
        OP_CMP  = 4'd4,  OP_AND  = 4'd5,  OP_OR   = 4'd6,  OP_XOR  = 4'd7,
        OP_SHR  = 4'd8,  OP_SHL  = 4'd9,  OP_NEG  = 4'd10, OP_ABS  = 4'd11,
        OP_MLD  = 4'd12, OP_MADD = 4'd13, OP_MSUB = 4'd14, OP_RSVD = 4'd15
    } mac_op_e;

    typedef enum logic [1:0] {
        SRC_WORD  = 2'd0,
        SRC_PROD  = 2'd1,
        SRC_SHORT = 2'd2,
        SRC_ALT   = 2'd3
    } mac_src_e;

    typedef struct packed {
        logic [MAC_AW-1:0] acc;
        logic [MAC_AW-1:0] prod;
        logic [MAC_SW-1:0] status;
    } mac_state_t;
endpackage

// File: rtl/mac_product.sv
module mac_product
    import mac_pkg::*;
(
    input  logic [MAC_DW-1:0] mul_a,
    input  logic [MAC_DW-1:0] mul_b,
    output logic [MAC_AW-1:0] prod_dbl
);
    localparam int unsigned EXT = MAC_AW - MAC_DW;

    logic signed [MAC_AW-1:0] a_ext;
    logic signed [MAC_AW-1:0] b_ext;
    logic signed [MAC_AW-1:0] full;

    always_comb begin
        a_ext    = {{EXT{mul_a[MAC_DW-1]}}, mul_a};
        b_ext    = {{EXT{mul_b[MAC_DW-1]}}, mul_b};
        full     = a_ext * b_ext;
        prod_dbl = {full[MAC_AW-2:0], 1'b0};
    end
endmodule

// File: rtl/mac_alu.sv
module mac_alu
    import mac_pkg::*;
(
    input  mac_op_e           op,
    input  mac_src_e          src,
    input  logic [MAC_DW-1:0] operand,
    input  logic [MAC_AW-1:0] acc,
    input  logic [MAC_AW-1:0] prod,
    output logic [MAC_AW-1:0] acc_next,
    output logic [MAC_AW-1:0] flag_res,
    output logic              flag_upd,
    output logic              prod_load
);
    localparam int unsigned IMM_PAD = MAC_DW - MAC_IMMW;

    logic [MAC_AW-1:0] src_val;
    logic [MAC_AW-1:0] diff;

    always_comb begin
        unique case (src)
            SRC_PROD:  src_val = prod;
            SRC_SHORT: src_val = {{IMM_PAD{1'b0}}, operand[MAC_IMMW-1:0], {MAC_DW{1'b0}}};
            default:   src_val = {operand, {MAC_DW{1'b0}}};
        endcase
        diff = acc - src_val;
    end

    always_comb begin
        acc_next  = acc;
        flag_upd  = 1'b1;
        prod_load = 1'b0;
        unique case (op)
            OP_LOAD: begin
                flag_upd = 1'b0;
                if (src == SRC_PROD) acc_next = prod;
                else                 acc_next = {src_val[MAC_AW-1:MAC_DW], acc[MAC_DW-1:0]};
            end
            OP_ADD:  acc_next = acc + src_val;
            OP_SUB:  acc_next = diff;
            OP_CMP:  acc_next = acc;
            OP_AND:  acc_next = acc & src_val;
            OP_OR:   acc_next = acc | src_val;
            OP_XOR:  acc_next = acc ^ src_val;
            OP_SHR:  acc_next = {acc[MAC_AW-1], acc[MAC_AW-1:1]};
            OP_SHL:  acc_next = {acc[MAC_AW-2:0], 1'b0};
            OP_NEG:  acc_next = '0 - acc;
            OP_ABS:  acc_next = acc[MAC_AW-1] ? ('0 - acc) : acc;
            OP_MLD: begin
                acc_next  = '0;
                prod_load = 1'b1;
            end
            OP_MADD: begin
                acc_next  = acc + prod;
                prod_load = 1'b1;
            end
            OP_MSUB: begin
                acc_next  = acc - prod;
                prod_load = 1'b1;
            end
            default: flag_upd = 1'b0;
        endcase
        flag_res = (op == OP_CMP) ? diff : acc_next;
    end
endmodule

// File: rtl/mac_flags.sv
module mac_flags
    import mac_pkg::*;
(
    input  logic [MAC_SW-1:0] st_in,
    input  logic              upd,
    input  logic [MAC_AW-1:0] res,
    output logic [MAC_SW-1:0] st_out
);
    always_comb begin
        st_out = st_in;
        if (upd) begin
            st_out[ST_L] = 1'b0;
            st_out[ST_V] = 1'b0;
            st_out[ST_Z] = ~|res;
            st_out[ST_N] = res[MAC_AW-1];
        end
    end
endmodule

// File: rtl/mac_acc_unit.sv
module mac_acc_unit
    import mac_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_valid,
    input  logic [3:0]  op_sel,
    input  logic [1:0]  src_sel,
    input  logic [15:0] operand,
    input  logic [15:0] x_in,
    input  logic [15:0] y_in,
    output logic [31:0] acc_o,
    output logic [31:0] prod_o,
    output logic [15:0] status_o
);
    mac_state_t        st_q;
    mac_state_t        st_d;
    logic [MAC_AW-1:0] prod_new;
    logic [MAC_AW-1:0] alu_acc;
    logic [MAC_AW-1:0] alu_res;
    logic              alu_flag_upd;
    logic              alu_prod_load;
    logic [MAC_SW-1:0] status_new;

    mac_product u_product (
        .mul_a    (x_in),
        .mul_b    (y_in),
        .prod_dbl (prod_new)
    );

    mac_alu u_alu (
        .op        (mac_op_e'(op_sel)),
        .src       (mac_src_e'(src_sel)),
        .operand   (operand),
        .acc       (st_q.acc),
        .prod      (st_q.prod),
        .acc_next  (alu_acc),
        .flag_res  (alu_res),
        .flag_upd  (alu_flag_upd),
        .prod_load (alu_prod_load)
    );

    mac_flags u_flags (
        .st_in  (st_q.status),
        .upd    (alu_flag_upd),
        .res    (alu_res),
        .st_out (status_new)
    );

    always_comb begin
        st_d = st_q;
        if (op_valid) begin
            st_d.acc    = alu_acc;
            st_d.status = status_new;
            if (alu_prod_load) st_d.prod = prod_new;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o    = st_q.acc;
    assign prod_o   = st_q.prod;
    assign status_o = st_q.status;
endmodule

// File: rtl/mac_acc_checker.sv
module mac_acc_checker
    import mac_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [3:0]  op_sel,
    input logic [15:0] x_in,
    input logic [15:0] y_in,
    input logic [31:0] acc_o,
    input logic [31:0] prod_o,
    input logic [15:0] status_o
);
    logic        is_mul;
    logic        tracks_acc;
    logic [31:0] exp_prod;

    always_comb begin
        is_mul     = op_valid && (op_sel >= 4'd12) && (op_sel <= 4'd14);
        tracks_acc = op_valid && (op_sel >= 4'd2) && (op_sel <= 4'd14) && (op_sel != 4'd4);
        exp_prod   = 32'($signed(x_in) * $signed(y_in) * 2);
    end

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(acc_o) && $stable(prod_o) && $stable(status_o))); // R2
    AST_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        is_mul |=> (prod_o == $past(exp_prod))); // R3
    AST_MLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'd12) |=> (acc_o == 32'd0 && status_o[13])); // R4
    AST_MADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'd13) |=> (acc_o == $past(acc_o) + $past(prod_o))); // R5
    AST_CMP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'd4) |=> $stable(acc_o)); // R7
    AST_FLAGS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        tracks_acc |=> (status_o[13] == (acc_o == 32'd0) && status_o[15] == acc_o[31])); // R10
    AST_STATUS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o & 16'h5FFF) == 16'h0000); // R10
    AST_LOAD_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'd1) |=> $stable(status_o)); // R11
endmodule

bind mac_acc_unit mac_acc_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_sel   (op_sel),
    .x_in     (x_in),
    .y_in     (y_in),
    .acc_o    (acc_o),
    .prod_o   (prod_o),
    .status_o (status_o)
);

// File: tb/mac_acc_unit_bench.sv
`timescale 1ns/1ps
module mac_acc_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [1:0]  src_sel = '0;
    logic [15:0] operand = '0;
    logic [15:0] x_in = '0;
    logic [15:0] y_in = '0;
    logic [31:0] acc_o;
    logic [31:0] prod_o;
    logic [15:0] status_o;

    int checks = 0;
    int fails  = 0;
    logic [31:0] m_acc  = '0;
    logic [31:0] m_prod = '0;
    logic [15:0] m_st   = '0;

    always #2.5 clk = ~clk;

    mac_acc_unit u_mac_acc_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .src_sel(src_sel), .operand(operand), .x_in(x_in), .y_in(y_in),
        .acc_o(acc_o), .prod_o(prod_o), .status_o(status_o)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic v, input logic [3:0] o, input logic [1:0] s);
        if (!v || o == 4'd0 || o == 4'd15) return "R2";
        if (o == 4'd1) return "R11";
        if (o == 4'd4) return "R7";
        if (o == 4'd12) return "R4";
        if (o == 4'd13 || o == 4'd14) return "R5";
        if (o >= 4'd8) return "R12";
        if (s == 2'd1) return "R8";
        if (s == 2'd2) return "R9";
        return "R6";
    endfunction

    task automatic step(input logic v, input logic [3:0] o, input logic [1:0] s,
                        input logic [15:0] w, input logic [15:0] x, input logic [15:0] y);
        logic [31:0] srcv, na, np, res;
        logic [15:0] ns;
        logic        fu;
        string       t;
        op_valid = v; op_sel = o; src_sel = s; operand = w; x_in = x; y_in = y;
        srcv = (s == 2'd1) ? m_prod : (s == 2'd2) ? {8'h00, w[7:0], 16'h0000} : {w, 16'h0000};
        na = m_acc; np = m_prod; ns = m_st; fu = 1'b1; res = 32'h0;
        if (v) begin
            case (o)
                4'd1: begin fu = 1'b0; na = (s == 2'd1) ? m_prod : {srcv[31:16], m_acc[15:0]}; end
                4'd2: na = m_acc + srcv;
                4'd3: na = m_acc - srcv;
                4'd4: res = m_acc - srcv;
                4'd5: na = m_acc & srcv;
                4'd6: na = m_acc | srcv;
                4'd7: na = m_acc ^ srcv;
                4'd8: na = 32'($signed(m_acc) >>> 1);
                4'd9: na = m_acc << 1;
                4'd10: na = 32'd0 - m_acc;
                4'd11: na = m_acc[31] ? 32'd0 - m_acc : m_acc;
                4'd12: na = 32'd0;
                4'd13: na = m_acc + m_prod;
                4'd14: na = m_acc - m_prod;
                default: fu = 1'b0;
            endcase
            if (o >= 4'd12 && o <= 4'd14) np = 32'($signed(x) * $signed(y) * 2);
            if (o != 4'd4) res = na;
            if (fu) begin
                ns = m_st & 16'h0FFF;
                if (res == 32'd0) ns[13] = 1'b1;
                ns[15] = res[31];
            end
        end else fu = 1'b0;
        @(posedge clk);
        @(negedge clk);
        t = tag_of(v, o, s);
        chk(t, "acc", acc_o, na);
        chk((v && o >= 4'd12 && o <= 4'd14) ? "R3" : t, "prod", prod_o, np);
        chk(fu ? "R10" : t, "status", {16'h0, status_o}, {16'h0, ns});
        m_acc = na; m_prod = np; m_st = ns;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "acc reset", acc_o, 32'h0);
        chk("R1", "prod reset", prod_o, 32'h0);
        chk("R1", "status reset", {16'h0, status_o}, 32'h0);
        // R3 corner: both operands most negative
        step(1, 4'd12, 0, 16'h0, 16'h8000, 16'h8000);
        step(1, 4'd1, 1, 16'h0, 16'h0, 16'h0);      // R11 load P
        step(1, 4'd11, 0, 16'h0, 16'h0, 16'h0);     // R12 abs of min
        step(1, 4'd10, 0, 16'h0, 16'h0, 16'h0);     // R12 negate of min
        step(1, 4'd8, 0, 16'h0, 16'h0, 16'h0);      // R12 shr negative
        step(1, 4'd1, 0, 16'h1234, 16'h0, 16'h0);   // R11 keeps low half
        step(1, 4'd4, 0, 16'h1234, 16'h0, 16'h0);   // R7 compare
        step(1, 4'd2, 2, 16'hAB12, 16'h0, 16'h0);   // R9 upper byte ignored
        step(0, 4'd2, 0, 16'hFFFF, 16'h7FFF, 16'h7FFF); // R2 idle
        step(1, 4'd15, 0, 16'hFFFF, 16'h1, 16'h1);  // R2 reserved code
        step(1, 4'd13, 0, 16'h0, 16'h7FFF, 16'hFFFF);
        step(1, 4'd14, 0, 16'h0, 16'h0003, 16'hFFFE);
        step(1, 4'd2, 1, 16'h0, 16'h0, 16'h0);      // R8 add P
        step(1, 4'd3, 3, 16'h0001, 16'h0, 16'h0);   // R9 alt acts as word
        for (int i = 0; i < 600; i++) begin
            logic [3:0] o;
            o = (($urandom % 4) == 0) ? 4'(12 + $urandom_range(0, 2)) : 4'($urandom_range(0, 15));
            step(($urandom % 10) != 0, o, 2'($urandom_range(0, 3)), 16'($urandom),
                 (($urandom % 8) == 0) ? 16'h8000 : 16'($urandom), 16'($urandom));
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule